// File: doc/BRIEF.md
# Eight-Point Streaming DCT-IV Core

This core computes a type-IV discrete cosine transform of length eight on a stream of signed fixed-point samples. A block is eight samples that arrive on consecutive clocks. The first sample comes with a one-clock start pulse, and eight clocks follow in which the input is not looked at. The core works in fixed-point arithmetic. It uses the integer coefficients round(2^17 * cos(m*pi/32)) for odd m, and for every odd product (2n+1)(2k+1) it folds the angle back onto one of these coefficients with a sign.

The results leave on alternate clocks in a fixed permuted coefficient order. Three signals travel with them:
- a lead marker, two clocks ahead of the first word;
- an output strobe, one clock ahead of each word;
- a 3-bit tag that names the coefficient number of the word.

Blocks can follow each other with no gap. This happens either through a fresh start pulse sixteen clocks after the previous one, or by holding the chain enable high so that the next block starts by itself.

Top module: `dct4_stream8`

## Requirements
- R1: Each result word equals floor(S / 2^(17 + OUT_RSHIFT + IN_W - OUT_W)), where S = sum over n of x_n * C(n,k). C(n,k) is round(131072 * cos(pi*(2n+1)*(2k+1)/32)), which always equals +/- one of 130441, 125428, 115595, 101320, 83151, 61787, 38048 or 12847. No rounding adder is applied.
- R2: The eight results of a block leave on every second clock in the order Y0, Y7, Y4, Y3, Y1, Y6, Y2, Y5. If the start pulse is in clock t, Y0 is on `coef_out` in clock t+11 and the last word is there in clock t+25.
- R3: With OUT_RSHIFT of 3 or more, no input block can overflow the output word. The arithmetic sum, shifted right, always fits in OUT_W bits.
- R4: `out_en` is high for exactly one clock immediately before each result word, and it is never high on two clocks in a row.
- R5: `lead_mark` is a one-clock pulse in clock t+9, two clocks before Y0 of that block.
- R6: `coef_idx` carries the coefficient number k (0..7) of the word on `coef_out` in the same clock.
- R7: The sample in the start clock is x0, and x1..x7 follow on the next seven clocks. Input on the eight clocks after x7 has no effect on any result.
- R8: A start pulse exactly sixteen clocks after the previous one gives a seamless output. The last word of one block and the lead marker of the next share a clock, and all results stay correct.
- R9: If `chain_en` is high in the fifteenth clock of a block (phase 14), the next block begins two clocks later without a start pulse. If it is low there, the core stops after the block. With no block running, `chain_en` alone starts nothing.
- R10: Synchronous reset clears the sequencers. After reset, `out_en` and `lead_mark` are low, and `coef_out` and `coef_idx` are zero until the first start. A reset during a block abandons that block, so no marker or result from it appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| blk_start | input | 1 | One-clock pulse in the same clock as sample x0 |
| chain_en | input | 1 | Sampled at phase 14; when high, the next block follows without a start pulse |
| din | input | IN_W | Signed input sample |
| coef_out | output | OUT_W | Signed result word |
| out_en | output | 1 | High one clock before each result word |
| lead_mark | output | 1 | One-clock pulse two clocks before Y0 |
| coef_idx | output | 3 | Coefficient number of the word on coef_out |

## Verification
The hardest case to reach is the handover between blocks. Here the hold bank is reloaded on the same edge that finishes the last result of the previous block. The restart decision also comes from a level sampled two clocks before that edge, not from a pulse. The stimulus reaches this case in two ways: a run of seven blocks started exactly sixteen clocks apart, and a chain of three blocks driven only by `chain_en`, which is dropped during the last block. Both runs drive deliberate garbage into the idle input slots. Full-scale vectors of the same sign and of alternating sign push the accumulator to its largest magnitude.

// File: rtl/dct4_pkg.sv
`timescale 1ns/1ps
package dct4_pkg;

  localparam int NPT      = 8;   // transform length
  localparam int PHASES   = 16;  // clocks per block slot
  localparam int COS_FRAC = 17;  // fractional bits of the coefficients
  localparam int COEF_W   = 18;  // signed coefficient width

  // magnitudes round(2^17 * cos(m*pi/32)) for odd m below 16
  localparam int COS_M1  = 130441;
  localparam int COS_M3  = 125428;
  localparam int COS_M5  = 115595;
  localparam int COS_M7  = 101320;
  localparam int COS_M9  = 83151;
  localparam int COS_M11 = 61787;
  localparam int COS_M13 = 38048;
  localparam int COS_M15 = 12847;

  // Signed coefficient for sample n and output k.
  // The angle (2n+1)(2k+1)*pi/32 is folded modulo 2*pi, mirrored about pi,
  // and reflected about pi/2 with a sign change.
  function automatic logic signed [COEF_W-1:0] cos_coef(input logic [2:0] n,
                                                        input logic [2:0] k);
    logic [7:0]  prod;
    logic [5:0]  m;
    logic        neg;
    logic [16:0] mag;
    prod = {4'b0, n, 1'b1} * {4'b0, k, 1'b1};
    m    = prod[5:0];
    if (m > 6'd32) m = 6'd0 - m;
    neg = (m > 6'd16);
    if (neg) m = 6'd32 - m;
    case (m)
      6'd1:    mag = 17'(COS_M1);
      6'd3:    mag = 17'(COS_M3);
      6'd5:    mag = 17'(COS_M5);
      6'd7:    mag = 17'(COS_M7);
      6'd9:    mag = 17'(COS_M9);
      6'd11:   mag = 17'(COS_M11);
      6'd13:   mag = 17'(COS_M13);
      6'd15:   mag = 17'(COS_M15);
      default: mag = 17'd0;
    endcase
    return neg ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  endfunction

  // Output slot j carries coefficient number slot_coef(j).
  function automatic logic [2:0] slot_coef(input logic [2:0] j);
    case (j)
      3'd0:    return 3'd0;
      3'd1:    return 3'd7;
      3'd2:    return 3'd4;
      3'd3:    return 3'd3;
      3'd4:    return 3'd1;
      3'd5:    return 3'd6;
      3'd6:    return 3'd2;
      default: return 3'd5;
    endcase
  endfunction

endpackage

// File: rtl/dct4_in_seq.sv
`timescale 1ns/1ps
module dct4_in_seq
  import dct4_pkg::*;
#(
  parameter int IN_W = 24
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      blk_start,
  input  logic                      chain_en,
  input  logic [IN_W-1:0]           din,
  output logic [NPT-1:0][IN_W-1:0]  hold_bank,
  output logic                      frame_load
);

  localparam int PH_W    = $clog2(PHASES);
  localparam int LOAD_PH = NPT;          // first idle phase: all samples present
  localparam int CHAIN_PH = PHASES - 2;  // phase at which chain_en is sampled

  logic                     in_run;
  logic [PH_W-1:0]          in_ph;
  logic                     chain_q;
  logic [NPT-1:0][IN_W-1:0] cap_bank;

  logic            active;
  logic [PH_W-1:0] cur_ph;

  assign active     = blk_start | in_run;
  assign cur_ph     = blk_start ? '0 : in_ph;
  assign frame_load = active && (cur_ph == PH_W'(LOAD_PH));

  always_ff @(posedge clk) begin
    if (rst) begin
      in_run  <= 1'b0;
      in_ph   <= '0;
      chain_q <= 1'b0;
    end else if (active) begin
      in_ph  <= cur_ph + PH_W'(1);
      in_run <= (cur_ph == PH_W'(PHASES - 1)) ? chain_q : 1'b1;
      if (cur_ph == PH_W'(CHAIN_PH)) chain_q <= chain_en;
    end
  end

  // capture slots: phases below NPT write the sample, the rest are ignored
  always_ff @(posedge clk) begin
    if (active && (cur_ph < PH_W'(NPT)))
      cap_bank[cur_ph[$clog2(NPT)-1:0]] <= din;
  end

  // second bank frees the capture bank for the next block
  always_ff @(posedge clk) begin
    if (frame_load) hold_bank <= cap_bank;
  end

endmodule

// File: rtl/dct4_mac.sv
`timescale 1ns/1ps
module dct4_mac
  import dct4_pkg::*;
#(
  parameter int IN_W  = 24,
  parameter int ACC_W = 48
) (
  input  logic                      clk,
  input  logic [NPT-1:0][IN_W-1:0]  hold_bank,
  input  logic [2:0]                coef_k,
  input  logic                      lower_half,
  input  logic                      keep_partial,
  output logic signed [ACC_W-1:0]   acc_sum
);

  localparam int HALF   = NPT / 2;
  localparam int PROD_W = IN_W + COEF_W;

  logic signed [PROD_W-1:0] prod [HALF];
  logic signed [ACC_W-1:0]  half_sum;
  logic signed [ACC_W-1:0]  partial;

  // four multipliers, shared between samples 0..3 and 4..7
  for (genvar g = 0; g < HALF; g++) begin : g_mul
    logic [2:0] n_sel;
    assign n_sel   = lower_half ? 3'(g) : 3'(g + HALF);
    assign prod[g] = $signed(hold_bank[n_sel]) * cos_coef(n_sel, coef_k);
  end

  always_comb begin
    half_sum = '0;
    for (int g = 0; g < HALF; g++) half_sum = half_sum + ACC_W'(prod[g]);
  end

  always_ff @(posedge clk) begin
    if (keep_partial) partial <= half_sum;
  end

  assign acc_sum = partial + half_sum;

endmodule

// File: rtl/dct4_out_seq.sv
`timescale 1ns/1ps
module dct4_out_seq
  import dct4_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       frame_load,
  output logic [$clog2(PHASES)-1:0]  out_ph,
  output logic                       out_run,
  output logic                       out_en,
  output logic                       lead_mark
);

  localparam int PH_W = $clog2(PHASES);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_ph    <= '0;
      out_run   <= 1'b0;
      out_en    <= 1'b0;
      lead_mark <= 1'b0;
    end else begin
      if (frame_load) begin
        out_ph  <= '0;
        out_run <= 1'b1;
      end else if (out_run) begin
        out_ph <= out_ph + PH_W'(1);
        if (out_ph == PH_W'(PHASES - 1)) out_run <= 1'b0;
      end
      // strobe on odd output phases, word follows on the next even phase
      out_en    <= out_run && !out_ph[0];
      lead_mark <= frame_load;
    end
  end

endmodule

// File: rtl/dct4_stream8.sv
`timescale 1ns/1ps
module dct4_stream8
  import dct4_pkg::*;
#(
  parameter int IN_W       = 24,
  parameter int OUT_W      = 24,
  parameter int OUT_RSHIFT = 3,
  parameter int ACC_W      = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             blk_start,
  input  logic             chain_en,
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] coef_out,
  output logic             out_en,
  output logic             lead_mark,
  output logic [2:0]       coef_idx
);

  localparam int PH_W  = $clog2(PHASES);
  localparam int SHIFT = COS_FRAC + OUT_RSHIFT + IN_W - OUT_W;

  logic [NPT-1:0][IN_W-1:0] hold_bank;
  logic                     frame_load;
  logic [PH_W-1:0]          out_ph;
  logic                     out_run;
  logic [2:0]               slot_k;
  logic                     lower_half;
  logic                     keep_partial;
  logic signed [ACC_W-1:0]  acc_sum;
  logic signed [ACC_W-1:0]  scaled;

  dct4_in_seq #(.IN_W(IN_W)) u_in (
    .clk        (clk),
    .rst        (rst),
    .blk_start  (blk_start),
    .chain_en   (chain_en),
    .din        (din),
    .hold_bank  (hold_bank),
    .frame_load (frame_load)
  );

  dct4_out_seq u_out (
    .clk        (clk),
    .rst        (rst),
    .frame_load (frame_load),
    .out_ph     (out_ph),
    .out_run    (out_run),
    .out_en     (out_en),
    .lead_mark  (lead_mark)
  );

  // slot j spans output phases 2j (lower half) and 2j+1 (upper half, finish)
  assign slot_k       = slot_coef(out_ph[3:1]);
  assign lower_half   = !out_ph[0];
  assign keep_partial = out_run && lower_half;

  dct4_mac #(.IN_W(IN_W), .ACC_W(ACC_W)) u_mac (
    .clk          (clk),
    .hold_bank    (hold_bank),
    .coef_k       (slot_k),
    .lower_half   (lower_half),
    .keep_partial (keep_partial),
    .acc_sum      (acc_sum)
  );

  assign scaled = acc_sum >>> SHIFT;

  always_ff @(posedge clk) begin
    if (rst) begin
      coef_out <= '0;
      coef_idx <= '0;
    end else if (out_en) begin
      coef_out <= scaled[OUT_W-1:0];
      coef_idx <= slot_k;
    end
  end

endmodule

// File: rtl/dct4_stream8_chk.sv
`timescale 1ns/1ps
module dct4_stream8_chk #(
  parameter int ACC_W = 48,
  parameter int OUT_W = 24,
  parameter int SHIFT = 20
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     out_en,
  input logic                     lead_mark,
  input logic                     out_run,
  input logic signed [ACC_W-1:0]  acc_sum
);

  logic signed [ACC_W-1:0] chk_scaled;
  logic signed [ACC_W-1:0] chk_wrapped;
  assign chk_scaled  = acc_sum >>> SHIFT;
  assign chk_wrapped = ACC_W'($signed(chk_scaled[OUT_W-1:0]));

  // R3: the word taken into coef_out survives truncation to OUT_W bits
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    out_en |-> (chk_wrapped == chk_scaled));

  // R4: strobe never on two clocks in a row
  a_r4_strobe_gap: assert property (@(posedge clk) disable iff (rst)
    out_en |=> !out_en);

  // R4: strobe only while an output frame is running
  a_r4_strobe_in_frame: assert property (@(posedge clk) disable iff (rst)
    out_en |-> out_run);

  // R5: marker lasts one clock
  a_r5_mark_single: assert property (@(posedge clk) disable iff (rst)
    lead_mark |=> !lead_mark);

  // R5: marker is followed by the strobe of Y0
  a_r5_mark_then_strobe: assert property (@(posedge clk) disable iff (rst)
    lead_mark |=> out_en);

  // R5: marker and strobe never coincide
  a_r5_mark_not_strobe: assert property (@(posedge clk) disable iff (rst)
    lead_mark |-> !out_en);

endmodule

bind dct4_stream8 dct4_stream8_chk #(
  .ACC_W (ACC_W),
  .OUT_W (OUT_W),
  .SHIFT (SHIFT)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .out_en    (out_en),
  .lead_mark (lead_mark),
  .out_run   (out_run),
  .acc_sum   (acc_sum)
);

// File: tb/test_dct4_stream8.sv
`timescale 1ns/1ps
module test_dct4_stream8;

  localparam int IN_W  = 24;
  localparam int OUT_W = 24;
  localparam int RSH   = 3;
  localparam int NBLK  = 7;
  localparam int SCALE = 17 + RSH + IN_W - OUT_W;

  localparam logic signed [IN_W-1:0] VEC [NBLK][8] = '{
    '{24'sd4194304, 24'sd0, 24'sd0, 24'sd0, 24'sd0, 24'sd0, 24'sd0, 24'sd0},
    '{24'sd0, 24'sd0, 24'sd0, 24'sd0, 24'sd0, 24'sd0, 24'sd0, -24'sd4194304},
    '{24'sd8388607, 24'sd8388607, 24'sd8388607, 24'sd8388607,
      24'sd8388607, 24'sd8388607, 24'sd8388607, 24'sd8388607},
    '{-24'sd8388608, -24'sd8388608, -24'sd8388608, -24'sd8388608,
      -24'sd8388608, -24'sd8388608, -24'sd8388608, -24'sd8388608},
    '{24'sd8388607, -24'sd8388608, 24'sd8388607, -24'sd8388608,
      24'sd8388607, -24'sd8388608, 24'sd8388607, -24'sd8388608},
    '{-24'sd3000000, 24'sd123457, 24'sd2222222, -24'sd77,
      24'sd5000000, -24'sd6543210, 24'sd999, 24'sd4000001},
    '{24'sd1, -24'sd1, 24'sd2, -24'sd2, 24'sd3, -24'sd3, 24'sd4, -24'sd4}
  };
  localparam int ORD [8] = '{0, 7, 4, 3, 1, 6, 2, 5};

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             blk_start = 1'b0;
  logic             chain_en = 1'b0;
  logic [IN_W-1:0]  din = '0;
  logic [OUT_W-1:0] coef_out;
  logic             out_en;
  logic             lead_mark;
  logic [2:0]       coef_idx;

  dct4_stream8 #(.IN_W(IN_W), .OUT_W(OUT_W), .OUT_RSHIFT(RSH), .ACC_W(48)) i_dct4_stream8 (
    .clk(clk), .rst(rst), .blk_start(blk_start), .chain_en(chain_en), .din(din),
    .coef_out(coef_out), .out_en(out_en), .lead_mark(lead_mark), .coef_idx(coef_idx)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;

  int                       mk_cyc [64];
  int                       n_mk = 0;
  int                       d_cyc  [256];
  logic signed [OUT_W-1:0]  d_val  [256];
  logic [2:0]               d_idx  [256];
  int                       n_d = 0;
  bit                       prev_en = 1'b0;

  int blk_t [32];
  int blk_v [32];
  int nb = 0;

  // monitor, away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      prev_en = 1'b0;
    end else begin
      if (lead_mark && n_mk < 64) begin
        mk_cyc[n_mk] = cyc;
        n_mk++;
      end
      if (prev_en && n_d < 256) begin
        d_cyc[n_d] = cyc;
        d_val[n_d] = coef_out;
        d_idx[n_d] = coef_idx;
        n_d++;
      end
      prev_en = out_en;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected result from the cosine definition, coefficients rounded to 2^-17
  function automatic longint ref_y(input int b, input int k);
    longint sum = 0;
    for (int n = 0; n < 8; n++) begin
      real    v;
      longint c;
      v = 131072.0 * $cos(3.141592653589793 * (2*n + 1) * (2*k + 1) / 32.0);
      c = (v >= 0.0) ? longint'($rtoi(v + 0.5)) : -longint'($rtoi(-v + 0.5));
      sum += longint'(VEC[b][n]) * c;
    end
    return sum >>> SCALE;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // one 16-clock slot: eight samples, then eight clocks of garbage (R7)
  task automatic drive_block(input int b, input bit st, input bit en);
    for (int i = 0; i < 16; i++) begin
      if (i == 0) begin
        blk_t[nb] = cyc;
        blk_v[nb] = b;
        nb++;
      end
      blk_start = st && (i == 0);
      din       = (i < 8) ? VEC[b][i] : (24'h5A5A5A ^ 24'(i * 7919));
      chain_en  = en;
      tick();
    end
    blk_start = 1'b0;
  endtask

  task automatic verify(input int b0, input int b1, input int mk0, input int d0);
    for (int b = b0; b <= b1; b++) begin
      int r = b - b0;
      check(mk_cyc[mk0 + r] == blk_t[b] + 9, "R5", "marker clock",
            mk_cyc[mk0 + r], blk_t[b] + 9);
      for (int j = 0; j < 8; j++) begin
        int e = d0 + 8*r + j;
        // R2 and R4: word in clock t+11+2j, strobe one clock earlier
        check(d_cyc[e] == blk_t[b] + 11 + 2*j, "R2 R4", "word clock",
              d_cyc[e], blk_t[b] + 11 + 2*j);
        check(d_idx[e] == 3'(ORD[j]), "R6", "index tag", d_idx[e], ORD[j]);
        // R1 value, R7 garbage in idle slots, R8 back-to-back handover
        check(longint'(d_val[e]) == ref_y(blk_v[b], ORD[j]), "R1 R7 R8",
              $sformatf("value blk %0d k %0d", blk_v[b], ORD[j]),
              longint'(d_val[e]), ref_y(blk_v[b], ORD[j]));
      end
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int mk0, d0, b0;

    // R10: reset state
    repeat (3) tick();
    @(negedge clk);
    check(!out_en && !lead_mark, "R10", "strobe/marker in reset",
          {out_en, lead_mark}, 0);
    @(posedge clk);
    #1 rst = 1'b0;
    repeat (4) tick();
    @(negedge clk);
    check(coef_out == '0, "R10", "coef_out after reset", coef_out, 0);
    check(coef_idx == 3'd0 && !out_en && !lead_mark, "R10", "idle outputs",
          {coef_idx, out_en, lead_mark}, 0);
    tick();

    // phase A: seven blocks by start pulses sixteen clocks apart (R8)
    mk0 = n_mk; d0 = n_d; b0 = nb;
    for (int b = 0; b < NBLK; b++) drive_block(b, 1'b1, 1'b0);
    repeat (30) tick();
    check(n_mk - mk0 == NBLK, "R8", "marker count", n_mk - mk0, NBLK);
    check(n_d - d0 == 8*NBLK, "R2", "word count", n_d - d0, 8*NBLK);
    if (n_mk - mk0 == NBLK && n_d - d0 == 8*NBLK) verify(b0, b0 + NBLK - 1, mk0, d0);

    // phase B: R9 chaining through chain_en, dropped in the last block
    mk0 = n_mk; d0 = n_d; b0 = nb;
    drive_block(4, 1'b1, 1'b1);
    drive_block(5, 1'b0, 1'b1);
    drive_block(2, 1'b0, 1'b0);
    repeat (30) tick();
    check(n_mk - mk0 == 3, "R9", "chained marker count", n_mk - mk0, 3);
    check(n_d - d0 == 24, "R9", "chained word count", n_d - d0, 24);
    if (n_mk - mk0 == 3 && n_d - d0 == 24) verify(b0, b0 + 2, mk0, d0);

    // phase C: R9 chain_en alone with no running block starts nothing
    mk0 = n_mk; d0 = n_d;
    chain_en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      din = 24'(i * 104729);
      tick();
    end
    chain_en = 1'b0;
    check(n_mk == mk0, "R9", "markers from chain_en alone", n_mk - mk0, 0);
    check(n_d == d0, "R9", "words from chain_en alone", n_d - d0, 0);

    // phase D: R10 reset in the middle of a block abandons it
    mk0 = n_mk; d0 = n_d;
    for (int i = 0; i < 5; i++) begin
      blk_start = (i == 0);
      chain_en  = 1'b1;
      din       = VEC[5][i];
      tick();
    end
    blk_start = 1'b0;
    rst = 1'b1;
    repeat (2) tick();
    rst = 1'b0;
    repeat (40) tick();
    chain_en = 1'b0;
    check(n_mk == mk0, "R10", "markers after mid-block reset", n_mk - mk0, 0);
    check(n_d == d0, "R10", "words after mid-block reset", n_d - d0, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule